// File: doc/BRIEF.md
# Asynchronous 16-bit bus slave bridge

This block lets a chip act as a slave on a 16-bit asynchronous microprocessor bus that uses address and data strobes. Every bus input is sampled on the rising edge of the bus clock. Each completed transfer becomes one request on a simple internal port. A write request carries the word address, the space select, per-byte enables and the buffered write data. A read request is answered by the internal side after a fixed number of clocks.

A transfer starts on the first clock edge where chip select, address strobe and at least one data strobe are all low. The acknowledge is driven high from that point on. After a number of clocks that depends on the memory-clock divider setting, it is pulled low to end the transfer. It is released once the master lifts the address strobe.

Write data is taken from the bus on one fixed edge, so the master only has to hold it valid around that edge. Read data is driven only on the byte lanes the master asked for. The acknowledge and each data byte lane have their own output-enable signal, which the pads use to produce high impedance.

Top module: `bus68_slave`

## Requirements
- R1: The first rising edge where `cs_n`, `as_n` and at least one of `uds_n`/`lds_n` are low starts a transfer. In the cycle after that edge, `dtack_oe` is 1 and `dtack_n` is 1.
- R2: `dtack_n` goes low in the cycle after the Nth rising edge of the transfer, counting the start edge as the first. N is 8, 11, 13 or 18 for `div_sel` = 0, 1, 2 or 3 (divider ratio 1 to 4). `dtack_n` stays high before that cycle.
- R3: On a write (`rw_n`=0), `dat_i` is captured on the third edge of the transfer, and data present on the other edges is ignored. In the cycle after the acknowledge edge, exactly one internal write is issued (`req_o`=1, `we_o`=1). It carries the latched address, `space_o` = sampled `mem_sel`, `be_o` = {!uds_n, !lds_n} from the capture edge, and the captured word.
- R4: On a read (`rw_n`=1), a read request (`req_o`=1, `we_o`=0) with the latched address and space is issued in the cycle after the start edge. `rdata_i` is sampled RD_LAT edges after the edge that accepts the request. It appears on `dat_o` when `dtack_n` falls.
- R5: During a read, `dat_oe_hi` follows !`uds_n` and `dat_oe_lo` follows !`lds_n`, both sampled on the previous edge. Both go to 0 on the first edge where the strobes are high. Neither is ever set during a write.
- R6: After the acknowledge, `dtack_oe` stays 1 with `dtack_n` low until the first rising edge where `as_n` (or `cs_n`) is high. It is 0 after that edge.
- R7: If `as_n` or `cs_n` is sampled high before the acknowledge edge, the transfer is aborted. No internal write is issued, and `dtack_oe`, `dat_oe_hi` and `dat_oe_lo` are 0 after that edge.
- R8: After reset, `dtack_oe`, `dat_oe_hi`, `dat_oe_lo` and `req_o` are 0 and `dtack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper byte strobe (bits 15:8), active low |
| lds_n | input | 1 | Lower byte strobe (bits 7:0), active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address |
| mem_sel | input | 1 | 1 = memory space, 0 = register space |
| div_sel | input | 2 | Memory-clock divider, 0..3 = ratio 1..4; held constant during a transfer |
| dat_i | input | 16 | Data bus, input side |
| dat_o | output | 16 | Data bus, output side |
| dat_oe_hi | output | 1 | Drive enable for bits 15:8 |
| dat_oe_lo | output | 1 | Drive enable for bits 7:0 |
| dtack_n | output | 1 | Acknowledge value, active low |
| dtack_oe | output | 1 | Acknowledge drive enable |
| req_o | output | 1 | Internal request pulse |
| we_o | output | 1 | Internal request is a write |
| addr_o | output | AW | Internal address |
| space_o | output | 1 | Internal space select |
| be_o | output | 2 | Internal byte enables {hi, lo} |
| wdata_o | output | 16 | Internal write data |
| rdata_i | input | 16 | Internal read data |

## Verification
The bench builds the block with AW=16 and RD_LAT=3, and its memory model drives garbage on `rdata_i` outside the one valid cycle, so a read sampled at the wrong edge shows up as a wrong value. It sweeps all four divider settings, both directions and the three strobe combinations. It checks the acknowledge level on every clock of each transfer, which pins the latency exactly. On writes, the bench drives the correct data only around the third edge, which exposes capture on any other edge. Aborts by either strobe or select confirm that no write leaks onto the internal port.

// File: rtl/bus68_slave.sv
module bus68_slave #(
  parameter int AW     = 16,
  parameter int RD_LAT = 2,
  parameter int ACK_D1 = 8,
  parameter int ACK_D2 = 11,
  parameter int ACK_D3 = 13,
  parameter int ACK_D4 = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          as_n,
  input  logic          uds_n,
  input  logic          lds_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  input  logic          mem_sel,
  input  logic [1:0]    div_sel,
  input  logic [15:0]   dat_i,
  output logic [15:0]   dat_o,
  output logic          dat_oe_hi,
  output logic          dat_oe_lo,
  output logic          dtack_n,
  output logic          dtack_oe,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          space_o,
  output logic [1:0]    be_o,
  output logic [15:0]   wdata_o,
  input  logic [15:0]   rdata_i
);
  localparam int CW = $clog2(ACK_D4 + 1);
  localparam logic [CW-1:0] CAP_W = CW'(2);
  localparam logic [CW-1:0] CAP_R = CW'(RD_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ACK} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ack_edge;
  logic          is_rd;

  wire sel    = !cs_n && !as_n;
  wire strobe = !uds_n || !lds_n;

  always_comb begin
    case (div_sel)
      2'd0:    ack_edge = CW'(ACK_D1 - 1);
      2'd1:    ack_edge = CW'(ACK_D2 - 1);
      2'd2:    ack_edge = CW'(ACK_D3 - 1);
      default: ack_edge = CW'(ACK_D4 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      is_rd     <= 1'b0;
      dtack_oe  <= 1'b0;
      dtack_n   <= 1'b1;
      dat_oe_hi <= 1'b0;
      dat_oe_lo <= 1'b0;
      req_o     <= 1'b0;
      we_o      <= 1'b0;
      addr_o    <= '0;
      space_o   <= 1'b0;
      be_o      <= 2'b00;
      wdata_o   <= '0;
      dat_o     <= '0;
    end else begin
      req_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sel && strobe) begin
            st        <= S_RUN;
            cnt       <= CW'(1);
            is_rd     <= rw_n;
            addr_o    <= addr;
            space_o   <= mem_sel;
            be_o      <= {!uds_n, !lds_n};
            dtack_oe  <= 1'b1;
            dtack_n   <= 1'b1;
            dat_oe_hi <= rw_n && !uds_n;
            dat_oe_lo <= rw_n && !lds_n;
            if (rw_n) begin
              req_o <= 1'b1;
              we_o  <= 1'b0;
            end
          end
        end
        S_RUN: begin
          if (!sel) begin
            st        <= S_IDLE;
            dtack_oe  <= 1'b0;
            dat_oe_hi <= 1'b0;
            dat_oe_lo <= 1'b0;
          end else begin
            cnt       <= cnt + CW'(1);
            dat_oe_hi <= is_rd && !uds_n;
            dat_oe_lo <= is_rd && !lds_n;
            if (is_rd && cnt == CAP_R)
              dat_o <= rdata_i;
            if (!is_rd && cnt == CAP_W) begin
              wdata_o <= dat_i;
              be_o    <= {!uds_n, !lds_n};
            end
            if (cnt == ack_edge) begin
              st      <= S_ACK;
              dtack_n <= 1'b0;
              if (!is_rd) begin
                req_o <= 1'b1;
                we_o  <= 1'b1;
              end
            end
          end
        end
        default: begin
          dat_oe_hi <= is_rd && !uds_n && sel;
          dat_oe_lo <= is_rd && !lds_n && sel;
          if (!sel) begin
            st       <= S_IDLE;
            dtack_oe <= 1'b0;
            dtack_n  <= 1'b1;
          end
        end
      endcase
    end
  end

  initial assert (RD_LAT >= 1 && RD_LAT + 2 <= ACK_D1)
    else $error("RD_LAT out of range for the fastest acknowledge");

  p_dtack_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_oe) |-> $past(!cs_n && !as_n));

  p_ack_as_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(!as_n && !cs_n));

  p_wr_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && we_o) |-> (dtack_oe && !dtack_n));

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  p_rd_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !we_o) |-> $past(!cs_n && !as_n && rw_n));

  p_lane_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe_hi |-> $past(!uds_n && rw_n));

  p_lane_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe_lo |-> $past(!lds_n && rw_n));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dtack_oe && !dtack_n && (as_n || cs_n)) |-> !dtack_oe);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dtack_oe && dtack_n && (as_n || cs_n)) |-> (!dtack_oe && !req_o && !dat_oe_hi && !dat_oe_lo));
endmodule

// File: tb/bus68_slave_tb_top.sv
module bus68_slave_tb_top;
  localparam int AW  = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1, as_n = 1, uds_n = 1, lds_n = 1, rw_n = 1, mem_sel = 0;
  logic [AW-1:0] addr = '0;
  logic [1:0]  div_sel = 2'd0;
  logic [15:0] dat_i = '0;
  logic [15:0] dat_o, wdata_o, rdata_i;
  logic dat_oe_hi, dat_oe_lo, dtack_n, dtack_oe, req_o, we_o, space_o;
  logic [AW-1:0] addr_o;
  logic [1:0] be_o;

  int nchk = 0, nfail = 0, nwr = 0;

  always #10 clk = ~clk;

  bus68_slave #(.AW(AW), .RD_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw_n(rw_n), .addr(addr), .mem_sel(mem_sel), .div_sel(div_sel), .dat_i(dat_i),
    .dat_o(dat_o), .dat_oe_hi(dat_oe_hi), .dat_oe_lo(dat_oe_lo), .dtack_n(dtack_n),
    .dtack_oe(dtack_oe), .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .space_o(space_o),
    .be_o(be_o), .wdata_o(wdata_o), .rdata_i(rdata_i));

  function automatic logic [15:0] memf(input logic [15:0] a, input logic sp);
    return {a[7:0] ^ 8'h5A, a[15:8]} ^ (sp ? 16'hF00F : 16'h0000);
  endfunction

  logic [2:0]  lat_q;
  logic [15:0] mem_q;
  always @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else if (req_o && !we_o) begin
      lat_q <= 3'(LAT);
      mem_q <= memf(addr_o, space_o);
    end else if (lat_q != 0) lat_q <= lat_q - 3'd1;
    if (rst_n && req_o && we_o) nwr <= nwr + 1;
  end
  assign rdata_i = (lat_q == 3'd1) ? mem_q : 16'hDEAD;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int ack_n(input logic [1:0] d);
    case (d)
      2'd0: return 8;
      2'd1: return 11;
      2'd2: return 13;
      default: return 18;
    endcase
  endfunction

  task automatic bus_cycle(input bit rd, input logic [15:0] a, input bit sp,
                           input bit u, input bit l, input logic [1:0] dv, input logic [15:0] wd);
    int e = ack_n(dv) - 1;
    logic [15:0] mask = {{8{!u}}, {8{!l}}};
    int wr0 = nwr;
    @(negedge clk);
    div_sel = dv; addr = a; mem_sel = sp; rw_n = rd; dat_i = ~wd;
    cs_n = 0; as_n = 0; uds_n = u; lds_n = l;
    for (int k = 0; k <= e; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R1 dtack_oe after start", dtack_oe, 1);
        chk("R1 dtack_n high after start", dtack_n, 1);
        if (rd) begin
          chk("R4 read req", {req_o, we_o}, 2'b10);
          chk("R4 read addr", addr_o, a);
          chk("R4 read space", space_o, sp);
        end
      end
      if (k < e) chk("R2 dtack_n before ack", dtack_n, 1);
      if (!rd) begin
        if (k == 1) dat_i = wd;
        if (k == 2) dat_i = ~wd;
        if (k < e) chk("R3 no early write", req_o, 0);
      end
    end
    chk("R2 dtack_n at ack", dtack_n, 0);
    chk("R2 dtack_oe at ack", dtack_oe, 1);
    if (rd) begin
      chk("R5 lane enables on read", {dat_oe_hi, dat_oe_lo}, {!u, !l});
      chk("R4 read data", dat_o & mask, memf(a, sp) & mask);
    end else begin
      chk("R3 write req", {req_o, we_o}, 2'b11);
      chk("R3 write data", wdata_o, wd);
      chk("R3 write be", be_o, {!u, !l});
      chk("R3 write addr", {space_o, addr_o}, {sp, a});
      chk("R5 no drive on write", {dat_oe_hi, dat_oe_lo}, 2'b00);
    end
    uds_n = 1; lds_n = 1;
    @(negedge clk);
    chk("R5 lanes off after strobes rise", {dat_oe_hi, dat_oe_lo}, 2'b00);
    chk("R6 dtack held until AS rises", {dtack_oe, dtack_n}, 2'b10);
    chk("R3 single write pulse", nwr - wr0, rd ? 0 : 1);
    as_n = 1; cs_n = 1;
    @(negedge clk);
    chk("R6 dtack released", {dtack_oe, dtack_n}, 2'b01);
  endtask

  task automatic abort_cycle(input bit by_cs, input logic [1:0] dv, input int at_k);
    int wr0 = nwr;
    @(negedge clk);
    div_sel = dv; addr = 16'h0BAD; mem_sel = 1; rw_n = 0; dat_i = 16'h7777;
    cs_n = 0; as_n = 0; uds_n = 0; lds_n = 0;
    for (int k = 0; k < at_k; k++) @(negedge clk);
    if (by_cs) cs_n = 1; else as_n = 1;
    @(negedge clk);
    chk("R7 outputs released on abort", {dtack_oe, dat_oe_hi, dat_oe_lo}, 3'b000);
    cs_n = 1; as_n = 1; uds_n = 1; lds_n = 1;
    repeat (ack_n(dv) + 2) @(negedge clk);
    chk("R7 no write after abort", nwr - wr0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset enables", {dtack_oe, dat_oe_hi, dat_oe_lo, req_o}, 4'b0000);
    chk("R8 reset dtack_n", dtack_n, 1);
    rst_n = 1;
    @(negedge clk);
    for (int dv = 0; dv < 4; dv++)
      for (int rd = 0; rd < 2; rd++)
        for (int sb = 0; sb < 3; sb++) begin
          logic [15:0] a = 16'h1234 + 16'(dv * 16'h0301 + rd * 16'h1111 + sb * 16'h0057);
          bus_cycle(rd[0], a, sb[0], sb == 1, sb == 0, 2'(dv), ~a ^ 16'(sb * 16'h0F0F));
        end
    abort_cycle(0, 2'd0, 3);
    abort_cycle(1, 2'd3, 10);
    abort_cycle(0, 2'd1, 1);
    bus_cycle(0, 16'hFFFF, 1, 0, 0, 2'd0, 16'hA55A);
    bus_cycle(1, 16'h0000, 0, 0, 0, 2'd2, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule